// File: doc/BRIEF.md
# Stereo Receive Interrupt Controller

This block keeps the receive-full state of a stereo serial audio receiver whose data receivers run side by side under one controller. The deserializer sends a strobe each time a left or right word lands in the receive data registers. The controller then raises a left-full or right-full flag and, if interrupts are enabled, drives one interrupt request along with the vector address that fits the current flag pattern.

Only one flag set gives a left or a right interrupt. Both flags set means the earlier word was overwritten, and this gives an overrun exception. In the single-flag case, the flag clears once software has read the data register of every enabled receiver. An overrun has a stricter rule: software must first read the control/status register, then read the data registers.

Software can move the vector table between a low base and a high base. Clearing the interrupt enable takes effect one cycle late. A software reset input returns the enable and location control bits to zero.

Top module: `stereo_rx_irq`

## Requirements
- R1: After `rst_ni` is released, both full flags, `irq_o` and `vec_addr_o` are 0. `irq_o` is never high while both flags are clear.
- R2: The cycle after a `left_done_i` pulse, `left_full_o` is 1. With interrupts enabled and only the left flag set, `irq_o` is 1 and the vector is 0x16.
- R3: The cycle after a `right_done_i` pulse, `right_full_o` is 1. With only the right flag set, the vector is 0x18.
- R4: When both flags are set, an enabled controller asserts `irq_o` with the exception vector 0x1A.
- R5: When `ctl_loc_i`=1 is written, the left, right and exception vectors move to 0x46, 0x48 and 0x4A. `vec_addr_o` is 0 when no flag is set.
- R6: A single set flag stays set until each enabled receiver's data register has been read at least once since the flag was set. It then clears, and `irq_o` drops.
- R7: A receiver whose `rx_en_i` bit is 0 is not needed to clear a flag. With only receiver 0 enabled, one read of receiver 0 clears the flag.
- R8: When both flags are set, data reads with no status read since the last word strobe leave both flags set. After a `stat_rd_i` pulse, data reads of all enabled receivers clear both flags.
- R9: With the enable at 0, the flags still set and clear as usual, but `irq_o` stays 0.
- R10: Writing the enable to 0 while a request is pending keeps `irq_o` high for one more cycle. `irq_o` drops in the cycle after that.
- R11: A `soft_rst_i` pulse clears the enable and location bits, and `irq_o` drops at once. The full flags are not changed.
- R12: A word strobe in the same cycle as the last needed data read wins. The flag stays set, and every enabled receiver must be read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Software reset of the control bits |
| left_done_i | input | 1 | Left word received strobe |
| right_done_i | input | 1 | Right word received strobe |
| rx_en_i | input | NUM_RX | Enabled receivers |
| stat_rd_i | input | 1 | Control/status register read strobe |
| data_rd_i | input | NUM_RX | Per-receiver data register read strobes |
| ctl_we_i | input | 1 | Control bit write strobe |
| ctl_ie_i | input | 1 | Interrupt enable write value |
| ctl_loc_i | input | 1 | Vector location write value |
| left_full_o | output | 1 | Left data full flag |
| right_full_o | output | 1 | Right data full flag |
| irq_o | output | 1 | Interrupt request |
| vec_addr_o | output | VEC_W | Selected vector word address |

## Verification
The bench uses the default parameters: two receivers, 8-bit vectors, bases 0x16 and 0x46, and a step of 2. With two receivers, a flag can be left with one read done and one still owed, which makes the partial-read state visible. Changing `rx_en_i` during the run also covers the case of a single enabled receiver. Both vector bases are reached through the location bit, so all six vector addresses are checked at the ports.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_LEFT  = 2'd1,
    KIND_RIGHT = 2'd2,
    KIND_EXC   = 2'd3
  } rx_kind_e;
endpackage

// File: rtl/rx_flag_track.sv
module rx_flag_track #(
  parameter int NUM_RX = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              left_done_i,
  input  logic              right_done_i,
  input  logic [NUM_RX-1:0] rx_en_i,
  input  logic              stat_rd_i,
  input  logic [NUM_RX-1:0] data_rd_i,
  output logic              left_full_o,
  output logic              right_full_o,
  output logic              tok_o
);
  logic [NUM_RX-1:0] pend_q, pend_clr, pend_nxt, rd_hit;
  logic lf_q, rf_q, tok_q, both, allow, done, strobe;

  assign both     = lf_q & rf_q;
  assign allow    = ~both | tok_q;
  assign rd_hit   = data_rd_i & rx_en_i;
  assign pend_clr = allow ? rd_hit : '0;
  assign pend_nxt = pend_q & ~pend_clr;
  assign done     = (lf_q | rf_q) & (|(pend_q & pend_clr)) & (pend_nxt == '0);
  assign strobe   = left_done_i | right_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      lf_q   <= 1'b0;
      rf_q   <= 1'b0;
      tok_q  <= 1'b0;
    end else if (strobe) begin
      // new word reloads the read obligation and drops any armed token
      pend_q <= rx_en_i;
      lf_q   <= lf_q | left_done_i;
      rf_q   <= rf_q | right_done_i;
      tok_q  <= 1'b0;
    end else if (done) begin
      pend_q <= '0;
      lf_q   <= 1'b0;
      rf_q   <= 1'b0;
      tok_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      if (stat_rd_i && both) tok_q <= 1'b1;
    end
  end

  assign left_full_o  = lf_q;
  assign right_full_o = rf_q;
  assign tok_o        = tok_q;
endmodule

// File: rtl/rx_irq_gate.sv
module rx_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic ctl_we_i,
  input  logic ctl_ie_i,
  input  logic ctl_loc_i,
  input  logic any_full_i,
  output logic irq_o,
  output logic ie_o,
  output logic ie_dly_o,
  output logic loc_o
);
  logic ie_q, ie_d, loc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      ie_d  <= 1'b0;
      loc_q <= 1'b0;
    end else if (soft_rst_i) begin
      ie_q  <= 1'b0;
      ie_d  <= 1'b0;
      loc_q <= 1'b0;
    end else begin
      ie_d <= ie_q;
      if (ctl_we_i) begin
        ie_q  <= ctl_ie_i;
        loc_q <= ctl_loc_i;
      end
    end
  end

  // delayed copy stretches the mask by one cycle on disable
  assign irq_o    = (ie_q | ie_d) & any_full_i;
  assign ie_o     = ie_q;
  assign ie_dly_o = ie_d;
  assign loc_o    = loc_q;
endmodule

// File: rtl/rx_vec_enc.sv
module rx_vec_enc
  import rx_irq_pkg::*;
#(
  parameter int           VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_LO   = 8'h16,
  parameter logic [VEC_W-1:0] VEC_HI   = 8'h46,
  parameter logic [VEC_W-1:0] VEC_STEP = 8'h02
) (
  input  logic             left_full_i,
  input  logic             right_full_i,
  input  logic             loc_i,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [VEC_W-1:0] STEP2 = VEC_STEP << 1;
  rx_kind_e         kind;
  logic [VEC_W-1:0] base;

  assign kind = rx_kind_e'({right_full_i, left_full_i});
  assign base = loc_i ? VEC_HI : VEC_LO;

  always_comb begin
    unique case (kind)
      KIND_LEFT:  vec_o = base;
      KIND_RIGHT: vec_o = base + VEC_STEP;
      KIND_EXC:   vec_o = base + STEP2;
      default:    vec_o = '0;
    endcase
  end
endmodule

// File: rtl/stereo_rx_irq.sv
module stereo_rx_irq #(
  parameter int               NUM_RX   = 2,
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_LO   = 8'h16,
  parameter logic [VEC_W-1:0] VEC_HI   = 8'h46,
  parameter logic [VEC_W-1:0] VEC_STEP = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              left_done_i,
  input  logic              right_done_i,
  input  logic [NUM_RX-1:0] rx_en_i,
  input  logic              stat_rd_i,
  input  logic [NUM_RX-1:0] data_rd_i,
  input  logic              ctl_we_i,
  input  logic              ctl_ie_i,
  input  logic              ctl_loc_i,
  output logic              left_full_o,
  output logic              right_full_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_addr_o
);
  logic lf, rf, tok, ie_now, ie_dly, loc_now;

  rx_flag_track #(.NUM_RX(NUM_RX)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .left_done_i  (left_done_i),
    .right_done_i (right_done_i),
    .rx_en_i      (rx_en_i),
    .stat_rd_i    (stat_rd_i),
    .data_rd_i    (data_rd_i),
    .left_full_o  (lf),
    .right_full_o (rf),
    .tok_o        (tok)
  );

  rx_irq_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .ctl_we_i   (ctl_we_i),
    .ctl_ie_i   (ctl_ie_i),
    .ctl_loc_i  (ctl_loc_i),
    .any_full_i (lf | rf),
    .irq_o      (irq_o),
    .ie_o       (ie_now),
    .ie_dly_o   (ie_dly),
    .loc_o      (loc_now)
  );

  rx_vec_enc #(
    .VEC_W(VEC_W), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI), .VEC_STEP(VEC_STEP)
  ) u_vec (
    .left_full_i  (lf),
    .right_full_i (rf),
    .loc_i        (loc_now),
    .vec_o        (vec_addr_o)
  );

  assign left_full_o  = lf;
  assign right_full_o = rf;
endmodule

// File: rtl/stereo_rx_irq_chk.sv
module stereo_rx_irq_chk #(
  parameter int NUM_RX = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              left_done_i,
  input logic              right_done_i,
  input logic [NUM_RX-1:0] data_rd_i,
  input logic              left_full_o,
  input logic              right_full_o,
  input logic              irq_o,
  input logic              tok,
  input logic              ie_now,
  input logic              ie_dly,
  input logic              loc_now
);
  p_irq_needs_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (left_full_o || right_full_o));

  p_left_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_done_i |=> left_full_o);

  p_right_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    right_done_i |=> right_full_o);

  p_clear_needs_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(left_full_o) |-> $past(|data_rd_i));

  p_overrun_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_full_o && right_full_o && !tok) |=> (left_full_o && right_full_o));

  p_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_now && !ie_dly) |-> !irq_o);

  p_soft_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!ie_now && !loc_now && !irq_o));
endmodule

bind stereo_rx_irq stereo_rx_irq_chk #(.NUM_RX(NUM_RX)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .left_done_i  (left_done_i),
  .right_done_i (right_done_i),
  .data_rd_i    (data_rd_i),
  .left_full_o  (left_full_o),
  .right_full_o (right_full_o),
  .irq_o        (irq_o),
  .tok          (tok),
  .ie_now       (ie_now),
  .ie_dly       (ie_dly),
  .loc_now      (loc_now)
);

// File: tb/tb_stereo_rx_irq.sv
`timescale 1ns/1ps
module tb_stereo_rx_irq;
  localparam int NUM_RX = 2;
  localparam int VEC_W  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic soft_rst_i = 1'b0, left_done_i = 1'b0, right_done_i = 1'b0;
  logic [NUM_RX-1:0] rx_en_i = '1, data_rd_i = '0;
  logic stat_rd_i = 1'b0, ctl_we_i = 1'b0, ctl_ie_i = 1'b0, ctl_loc_i = 1'b0;
  logic left_full_o, right_full_o, irq_o;
  logic [VEC_W-1:0] vec_addr_o;

  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  stereo_rx_irq dut (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .left_done_i(left_done_i), .right_done_i(right_done_i),
    .rx_en_i(rx_en_i), .stat_rd_i(stat_rd_i), .data_rd_i(data_rd_i),
    .ctl_we_i(ctl_we_i), .ctl_ie_i(ctl_ie_i), .ctl_loc_i(ctl_loc_i),
    .left_full_o(left_full_o), .right_full_o(right_full_o),
    .irq_o(irq_o), .vec_addr_o(vec_addr_o)
  );

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
    end
  endtask

  task automatic chk_out(input string tag, input int lf, input int rf,
                         input int irq, input int vec);
    chk({tag, " left_full"}, int'(left_full_o), lf);
    chk({tag, " right_full"}, int'(right_full_o), rf);
    chk({tag, " irq"}, int'(irq_o), irq);
    chk({tag, " vec"}, int'(vec_addr_o), vec);
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_ctl(input logic ie, input logic loc);
    ctl_we_i = 1'b1; ctl_ie_i = ie; ctl_loc_i = loc; tick(); ctl_we_i = 1'b0;
  endtask

  task automatic word(input logic l, input logic r);
    left_done_i = l; right_done_i = r; tick();
    left_done_i = 1'b0; right_done_i = 1'b0;
  endtask

  task automatic rd_data(input logic [NUM_RX-1:0] m);
    data_rd_i = m; tick(); data_rd_i = '0;
  endtask

  task automatic rd_stat();
    stat_rd_i = 1'b1; tick(); stat_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk_out("R1 reset", 0, 0, 0, 0);
  endtask

  task automatic t_left();
    wr_ctl(1'b1, 1'b0);
    word(1'b1, 1'b0);
    chk_out("R2 left", 1, 0, 1, 'h16);
    rd_data(2'b01);
    chk_out("R6 partial read", 1, 0, 1, 'h16);
    rd_data(2'b10);
    chk_out("R6 all read", 0, 0, 0, 0);
  endtask

  task automatic t_right();
    word(1'b0, 1'b1);
    chk_out("R3 right", 0, 1, 1, 'h18);
    rd_data(2'b11);
    chk_out("R6 right cleared", 0, 0, 0, 0);
  endtask

  task automatic t_overrun();
    word(1'b1, 1'b0);
    word(1'b0, 1'b1);
    chk_out("R4 overrun", 1, 1, 1, 'h1A);
    rd_data(2'b11);
    chk_out("R8 read without status", 1, 1, 1, 'h1A);
    rd_stat();
    chk_out("R8 status only", 1, 1, 1, 'h1A);
    rd_data(2'b01);
    chk_out("R8 first data read", 1, 1, 1, 'h1A);
    rd_data(2'b10);
    chk_out("R8 sequence done", 0, 0, 0, 0);
  endtask

  task automatic t_loc();
    wr_ctl(1'b1, 1'b1);
    word(1'b1, 1'b0);
    chk_out("R5 high left", 1, 0, 1, 'h46);
    rd_data(2'b11);
    word(1'b0, 1'b1);
    chk_out("R5 high right", 0, 1, 1, 'h48);
    word(1'b1, 1'b0);
    chk_out("R5 high exc", 1, 1, 1, 'h4A);
    rd_stat();
    rd_data(2'b11);
    chk_out("R5 none pending", 0, 0, 0, 0);
    wr_ctl(1'b1, 1'b0);
  endtask

  task automatic t_enabled_only();
    rx_en_i = 2'b01;
    word(1'b1, 1'b0);
    rd_data(2'b01);
    chk_out("R7 one receiver", 0, 0, 0, 0);
    rx_en_i = 2'b11;
  endtask

  task automatic t_poll();
    wr_ctl(1'b0, 1'b0);
    tick();
    word(1'b0, 1'b1);
    chk_out("R9 polled set", 0, 1, 0, 'h18);
    rd_data(2'b11);
    chk_out("R9 polled clear", 0, 0, 0, 0);
  endtask

  task automatic t_mask();
    wr_ctl(1'b1, 1'b0);
    word(1'b1, 1'b0);
    chk("R10 pending", int'(irq_o), 1);
    wr_ctl(1'b0, 1'b0);
    chk("R10 one cycle late", int'(irq_o), 1);
    tick();
    chk("R10 masked", int'(irq_o), 0);
    chk("R10 flag kept", int'(left_full_o), 1);
    rd_data(2'b11);
  endtask

  task automatic t_soft();
    wr_ctl(1'b1, 1'b1);
    word(1'b1, 1'b0);
    chk_out("R11 before", 1, 0, 1, 'h46);
    soft_rst_i = 1'b1; tick(); soft_rst_i = 1'b0;
    chk_out("R11 after", 1, 0, 0, 'h16);
    rd_data(2'b11);
  endtask

  task automatic t_race();
    wr_ctl(1'b1, 1'b0);
    word(1'b1, 1'b0);
    rd_data(2'b01);
    data_rd_i = 2'b10; left_done_i = 1'b1; tick();
    data_rd_i = '0; left_done_i = 1'b0;
    chk_out("R12 strobe wins", 1, 0, 1, 'h16);
    rd_data(2'b10);
    chk("R12 rx0 owed again", int'(left_full_o), 1);
    rd_data(2'b01);
    chk("R12 cleared", int'(left_full_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_left();
    t_right();
    t_overrun();
    t_loc();
    t_enabled_only();
    t_poll();
    t_mask();
    t_soft();
    t_race();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule